// File: doc/BRIEF.md
# Single-Wire Bus Identity Enumerator

This block is a bus-master engine that finds the 64-bit identities of every device on a shared open-drain single-wire bus. It does not produce slot waveforms. It drives a bit-level master through a request/acknowledge interface with three operations: reset with a presence check, write one bit, and read one bit. The bus is wired-AND, so a read returns 0 whenever any device still taking part pulls the line low.

After `start`, the engine runs search passes until the enumeration is complete. Each pass has five steps:

1. Reset the bus and check for presence.
2. Send the search command byte, least significant bit first. The byte is either the all-device search or the active-only search.
3. For each identity position, read the bit.
4. Read the bit's complement.
5. Write back the chosen direction. Devices whose bit differs from the written direction drop out for the rest of the pass.

Between passes the engine keeps the highest position at which a disagreement was resolved toward 0. On the next pass it repeats the earlier choices up to that position and takes 1 there, so every pass reaches a new device. Each found identity appears on `id_out` with a one-cycle `id_valid` strobe. When no untaken 0-branch is left, `done` is raised. A missing presence response or an impossible read pair raises `err` instead.

Top module: `sw_enum_top`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `id_valid` and `bit_req` are all 0.
- R2: A `start` accepted while not busy leads, on the next cycle, to a bit request with `bit_op` = 0 (bus reset). If that reset is acknowledged with `bit_rdata` = 0 (no presence), the engine stops with `err` = 1 and `busy` = 0, and it never pulses `id_valid`.
- R3: After each presence, eight write operations (`bit_op` = 1) send the command byte least significant bit first. The byte is 8'hF0 when `active_only` was 0 at the accepted `start`, and 8'hEC when it was 1.
- R4: For each identity position 0 to 63, the engine issues two reads (`bit_op` = 2): the bit, then its complement. It then issues one write. A 0-then-1 pair writes 0, and a 1-then-0 pair writes 1.
- R5: A 1-then-1 read pair ends the enumeration with `err` = 1 and no `id_valid` for that pass.
- R6: On a 0-then-0 pair, the engine behaves as follows, and as a result the identities come out ordered by bit 0 first, then bit 1, and so on, with 0 before 1. Each pass takes exactly one bus reset.
  - At a position below the remembered branch point, it writes the bit chosen at that position in the previous pass.
  - At the branch point itself, it writes 1.
  - Above the branch point, it writes 0.
- R7: At the end of each pass, `id_valid` is high for exactly one cycle. `id_out` bit i then equals the value written at position i.
- R8: When a pass ends with no 0-branch left untaken, `done` rises and `busy` falls. No further bit requests are made.
- R9: `start` is ignored while busy. A `start` accepted when idle, done or failed clears the branch memory, so enumeration begins again from the first identity.
- R10: `bit_req` stays high, with `bit_op` and `bit_wdata` held steady, until `bit_ack` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a fresh enumeration (accepted when not busy) |
| active_only | input | 1 | Selects the active-only search command, sampled at start |
| bit_req | output | 1 | Bit operation request, held until acknowledged |
| bit_op | output | 2 | Operation: 0 reset/presence, 1 write, 2 read |
| bit_wdata | output | 1 | Value to write for a write operation |
| bit_ack | input | 1 | One-cycle completion of the requested operation |
| bit_rdata | input | 1 | Read value, or presence (1) for a reset operation |
| busy | output | 1 | Enumeration in progress |
| id_out | output | ID_W | Identity found by the latest pass |
| id_valid | output | 1 | One-cycle strobe when `id_out` is new |
| done | output | 1 | All identities have been reported |
| err | output | 1 | Enumeration stopped: no presence or 1/1 read pair |

## Verification
The hardest situation to reach is a branch point high in the identity, including the very last position. There the engine must replay 62 or 63 earlier choices exactly and then take the other branch.

The bench reaches it with a behavioural model of several devices on a wired-AND bus. The model uses chosen identities that disagree only at bit 63, only at bit 0, or at scattered middle positions. Filtering the device set through the active-only command produces the 1/1 pair without any special stimulus. A `start` pulse injected mid-enumeration exercises the ignore rule.

// File: rtl/sw_enum_pkg.sv
package sw_enum_pkg;

    localparam int DEF_ID_W   = 64;
    localparam int DEF_CMD_W  = 8;
    localparam logic [7:0] DEF_CMD_ALL    = 8'hF0;
    localparam logic [7:0] DEF_CMD_ACTIVE = 8'hEC;

    // Bit-level operations issued to the slot engine
    typedef enum logic [1:0] {
        BOP_RESET = 2'd0,
        BOP_WRITE = 2'd1,
        BOP_READ  = 2'd2
    } bop_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RESET,
        ST_CMD,
        ST_RD_BIT,
        ST_RD_CMP,
        ST_WR_DIR,
        ST_PASS_END,
        ST_DONE,
        ST_FAIL
    } sst_e;

    // Bit/complement pair read at one identity position
    typedef struct packed {
        logic val;
        logic cmp;
    } pair_t;

    // Direction to write for a position
    function automatic logic pick_dir(pair_t p, logic old_bit, logic below, logic at_mark);
        if (p.val != p.cmp) return p.val;
        if (below) return old_bit;
        return at_mark;
    endfunction

    function automatic logic is_quiet(sst_e s);
        return (s == ST_IDLE) || (s == ST_DONE) || (s == ST_FAIL);
    endfunction

endpackage

// File: rtl/sw_enum_ctrl.sv
module sw_enum_ctrl
    import sw_enum_pkg::*;
#(
    parameter int ID_W  = DEF_ID_W,
    parameter int CMD_W = DEF_CMD_W,
    localparam int CNT_W = $clog2(ID_W),
    localparam int CMD_IDX_W = $clog2(CMD_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              active_only,
    input  logic              bit_ack,
    input  logic              bit_rdata,
    input  logic [CMD_W-1:0]  cmd_byte,
    input  logic              dir,
    input  logic              more_left,
    output logic              bit_req,
    output logic [1:0]        bit_op,
    output logic              bit_wdata,
    output logic [CNT_W-1:0]  pos_idx,
    output pair_t             pair,
    output logic              mode,
    output logic              clr_all,
    output logic              pass_go,
    output logic              commit,
    output logic              pass_end,
    output sst_e              state
);

    localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(ID_W - 1);
    localparam logic [CNT_W-1:0] LAST_CMD = CNT_W'(CMD_W - 1);

    sst_e             state_q;
    logic [CNT_W-1:0] cnt_q;
    pair_t            pair_q;
    logic             mode_q;

    always_comb begin
        bit_req   = 1'b0;
        bit_op    = BOP_RESET;
        bit_wdata = 1'b0;
        unique case (state_q)
            ST_RESET: begin
                bit_req = 1'b1;
                bit_op  = BOP_RESET;
            end
            ST_CMD: begin
                bit_req   = 1'b1;
                bit_op    = BOP_WRITE;
                bit_wdata = cmd_byte[cnt_q[CMD_IDX_W-1:0]];
            end
            ST_RD_BIT, ST_RD_CMP: begin
                bit_req = 1'b1;
                bit_op  = BOP_READ;
            end
            ST_WR_DIR: begin
                bit_req   = 1'b1;
                bit_op    = BOP_WRITE;
                bit_wdata = dir;
            end
            default: ;
        endcase
    end

    assign clr_all  = start && is_quiet(state_q);
    assign pass_go  = (state_q == ST_RESET) && bit_ack && bit_rdata;
    assign commit   = (state_q == ST_WR_DIR) && bit_ack;
    assign pass_end = (state_q == ST_PASS_END);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            pair_q  <= '0;
            mode_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE, ST_FAIL: begin
                    if (start) begin
                        mode_q  <= active_only;
                        state_q <= ST_RESET;
                    end
                end
                ST_RESET: begin
                    if (bit_ack) begin
                        cnt_q   <= '0;
                        state_q <= bit_rdata ? ST_CMD : ST_FAIL;
                    end
                end
                ST_CMD: begin
                    if (bit_ack) begin
                        if (cnt_q == LAST_CMD) begin
                            cnt_q   <= '0;
                            state_q <= ST_RD_BIT;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RD_BIT: begin
                    if (bit_ack) begin
                        pair_q.val <= bit_rdata;
                        state_q    <= ST_RD_CMP;
                    end
                end
                ST_RD_CMP: begin
                    if (bit_ack) begin
                        pair_q.cmp <= bit_rdata;
                        state_q    <= (pair_q.val && bit_rdata) ? ST_FAIL : ST_WR_DIR;
                    end
                end
                ST_WR_DIR: begin
                    if (bit_ack) begin
                        if (cnt_q == LAST_POS) begin
                            state_q <= ST_PASS_END;
                        end else begin
                            cnt_q   <= cnt_q + 1'b1;
                            state_q <= ST_RD_BIT;
                        end
                    end
                end
                ST_PASS_END: begin
                    state_q <= more_left ? ST_RESET : ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign pos_idx = cnt_q;
    assign pair    = pair_q;
    assign mode    = mode_q;
    assign state   = state_q;

endmodule

// File: rtl/sw_enum_branch.sv
module sw_enum_branch
    import sw_enum_pkg::*;
#(
    parameter int ID_W = DEF_ID_W,
    localparam int CNT_W = $clog2(ID_W),
    localparam int POS_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_all,
    input  logic             pass_go,
    input  logic             commit,
    input  logic             pass_end,
    input  logic [CNT_W-1:0] pos_idx,
    input  pair_t            pair,
    input  logic             old_bit,
    output logic             dir,
    output logic             more_left
);

    // Positions are 1-based here; 0 means "no branch point"
    logic [POS_W-1:0] mark_q;      // branch point from the previous pass
    logic [POS_W-1:0] zero_q;      // highest 0-taken conflict this pass
    logic [POS_W-1:0] pos;
    logic             conflict;

    assign pos      = POS_W'(pos_idx) + POS_W'(1);
    assign conflict = !pair.val && !pair.cmp;
    assign dir      = pick_dir(pair, old_bit, pos < mark_q, pos == mark_q);

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            mark_q <= '0;
            zero_q <= '0;
        end else begin
            if (pass_go) begin
                zero_q <= '0;
            end else if (commit && conflict && !dir) begin
                zero_q <= pos;
            end
            if (pass_end) begin
                mark_q <= zero_q;
            end
        end
    end

    assign more_left = (zero_q != '0);

endmodule

// File: rtl/sw_enum_idreg.sv
module sw_enum_idreg
    import sw_enum_pkg::*;
#(
    parameter int ID_W = DEF_ID_W,
    localparam int CNT_W = $clog2(ID_W)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             commit,
    input  logic [CNT_W-1:0] pos_idx,
    input  logic             dir,
    output logic             old_bit,
    output logic [ID_W-1:0]  id_q
);

    // Updated in place: a position still holds last pass's choice until written
    logic [ID_W-1:0] id_r;

    always_ff @(posedge clk) begin
        if (rst) begin
            id_r <= '0;
        end else if (commit) begin
            id_r[pos_idx] <= dir;
        end
    end

    assign old_bit = id_r[pos_idx];
    assign id_q    = id_r;

endmodule

// File: rtl/sw_enum_top.sv
module sw_enum_top
    import sw_enum_pkg::*;
#(
    parameter int         ID_W       = DEF_ID_W,
    parameter int         CMD_W      = DEF_CMD_W,
    parameter logic [7:0] CMD_ALL    = DEF_CMD_ALL,
    parameter logic [7:0] CMD_ACTIVE = DEF_CMD_ACTIVE
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            active_only,
    output logic            bit_req,
    output logic [1:0]      bit_op,
    output logic            bit_wdata,
    input  logic            bit_ack,
    input  logic            bit_rdata,
    output logic            busy,
    output logic [ID_W-1:0] id_out,
    output logic            id_valid,
    output logic            done,
    output logic            err
);

    localparam int CNT_W = $clog2(ID_W);

    logic [CNT_W-1:0] pos_idx;
    pair_t            pair;
    logic             mode, clr_all, pass_go, commit, pass_end;
    logic             dir, more_left, old_bit;
    logic [CMD_W-1:0] cmd_byte;
    sst_e             state;

    assign cmd_byte = mode ? CMD_W'(CMD_ACTIVE) : CMD_W'(CMD_ALL);

    sw_enum_ctrl #(.ID_W(ID_W), .CMD_W(CMD_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .active_only(active_only),
        .bit_ack(bit_ack), .bit_rdata(bit_rdata), .cmd_byte(cmd_byte),
        .dir(dir), .more_left(more_left),
        .bit_req(bit_req), .bit_op(bit_op), .bit_wdata(bit_wdata),
        .pos_idx(pos_idx), .pair(pair), .mode(mode),
        .clr_all(clr_all), .pass_go(pass_go), .commit(commit),
        .pass_end(pass_end), .state(state)
    );

    sw_enum_branch #(.ID_W(ID_W)) u_branch (
        .clk(clk), .rst(rst), .clr_all(clr_all), .pass_go(pass_go),
        .commit(commit), .pass_end(pass_end), .pos_idx(pos_idx),
        .pair(pair), .old_bit(old_bit), .dir(dir), .more_left(more_left)
    );

    sw_enum_idreg #(.ID_W(ID_W)) u_idreg (
        .clk(clk), .rst(rst), .commit(commit), .pos_idx(pos_idx),
        .dir(dir), .old_bit(old_bit), .id_q(id_out)
    );

    assign busy     = !is_quiet(state);
    assign id_valid = pass_end;
    assign done     = (state == ST_DONE);
    assign err      = (state == ST_FAIL);

endmodule

// File: rtl/sw_enum_chk.sv
module sw_enum_chk (
    input logic       clk,
    input logic       rst,
    input logic       start,
    input logic       busy,
    input logic       bit_req,
    input logic       bit_ack,
    input logic [1:0] bit_op,
    input logic       bit_wdata,
    input logic       id_valid,
    input logic       done,
    input logic       err
);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        bit_req && !bit_ack |=> bit_req && $stable(bit_op) && $stable(bit_wdata));

    // R7
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        id_valid |=> !id_valid);

    // R8
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !bit_req && !busy);

    // R2
    start_reset_chk: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> bit_req && bit_op == 2'd0);

    // R5
    fail_excl_chk: assert property (@(posedge clk) disable iff (rst)
        err |-> !done && !id_valid && !bit_req);

endmodule

bind sw_enum_top sw_enum_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .busy(busy), .bit_req(bit_req),
    .bit_ack(bit_ack), .bit_op(bit_op), .bit_wdata(bit_wdata),
    .id_valid(id_valid), .done(done), .err(err)
);

// File: tb/sw_enum_top_tb.sv
module sw_enum_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        active_only = 1'b0;
    logic        bit_ack = 1'b0;
    logic        bit_rdata = 1'b0;
    logic        bit_req, bit_wdata, busy, id_valid, done, err;
    logic [1:0]  bit_op;
    logic [63:0] id_out;

    always #10 clk = ~clk;

    sw_enum_top u_dut (
        .clk(clk), .rst(rst), .start(start), .active_only(active_only),
        .bit_req(bit_req), .bit_op(bit_op), .bit_wdata(bit_wdata),
        .bit_ack(bit_ack), .bit_rdata(bit_rdata), .busy(busy),
        .id_out(id_out), .id_valid(id_valid), .done(done), .err(err)
    );

    // Device identities on the modelled bus
    localparam logic [63:0] DEV [6] = '{
        64'h0000_0000_0000_0005,
        64'h8000_0000_0000_0005,   // differs from entry 0 only at bit 63
        64'h0000_0000_0000_0004,   // differs from entry 0 only at bit 0
        64'h1234_5678_9ABC_DEF1,
        64'hFFFF_FFFF_FFFF_FFFF,
        64'h0F0F_0000_0000_0005
    };
    localparam logic [5:0] ACT_MASK = 6'b101010;

    // Scenario vectors: {active_only, device mask}; expectations derived below
    localparam logic [6:0] SCEN [7] = '{
        {1'b0, 6'h3F}, {1'b1, 6'h3F}, {1'b0, 6'h01}, {1'b0, 6'h03},
        {1'b0, 6'h14}, {1'b0, 6'h00}, {1'b1, 6'h05}
    };

    int checks = 0;
    int errors = 0;

    // Bus model state
    logic [5:0] dev_mask = '0;
    logic [5:0] part;
    int         cmd_cnt, pos, n_resets = 0, hs_errs = 0, lat = 0;
    logic [7:0] cmd_rx, last_cmd = '0;
    bit         phase;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] rev64(input logic [63:0] x);
        logic [63:0] r;
        for (int i = 0; i < 64; i++) r[i] = x[63 - i];
        return r;
    endfunction

    // Wired-AND bus of devices, answering the bit-level requests
    initial begin
        logic [1:0] op;
        logic       wd, rd;
        forever begin
            @(negedge clk);
            if (bit_req && !rst) begin
                op = bit_op;
                wd = bit_wdata;
                repeat (lat % 3) begin
                    @(negedge clk);
                    if (!bit_req || bit_op != op || bit_wdata != wd) hs_errs++;
                end
                lat++;
                case (op)
                    2'd0: begin
                        n_resets++;
                        part = dev_mask; cmd_cnt = 0; pos = 0; phase = 0; cmd_rx = '0;
                        bit_rdata = |dev_mask;
                    end
                    2'd1: begin
                        if (cmd_cnt < 8) begin
                            cmd_rx[cmd_cnt] = wd;
                            cmd_cnt++;
                            if (cmd_cnt == 8) begin
                                last_cmd = cmd_rx;
                                if (cmd_rx == 8'hEC) part = part & ACT_MASK;
                            end
                        end else begin
                            for (int i = 0; i < 6; i++)
                                if (part[i] && DEV[i][pos] != wd) part[i] = 1'b0;
                            pos++;
                            phase = 0;
                        end
                    end
                    default: begin
                        rd = 1'b1;
                        for (int i = 0; i < 6; i++)
                            if (part[i]) rd = rd & (phase ? ~DEV[i][pos] : DEV[i][pos]);
                        phase = ~phase;
                        bit_rdata = rd;
                    end
                endcase
                bit_ack = 1'b1;
                @(negedge clk);
                bit_ack = 1'b0;
            end
        end
    end

    task automatic run_enum(input bit act, input logic [5:0] mask, input bit poke);
        logic [63:0] expv [6];
        logic [63:0] found [8];
        logic [63:0] t;
        logic [5:0]  elig;
        int n_exp = 0, nf = 0, r0, h0;
        bit fin = 0, poked = 0;
        elig = mask & (act ? ACT_MASK : 6'h3F);
        for (int i = 0; i < 6; i++) if (elig[i]) begin expv[n_exp] = DEV[i]; n_exp++; end
        for (int i = 0; i < n_exp; i++)
            for (int j = i + 1; j < n_exp; j++)
                if (rev64(expv[j]) < rev64(expv[i])) begin
                    t = expv[i]; expv[i] = expv[j]; expv[j] = t;
                end
        dev_mask = mask;
        active_only = act;
        r0 = n_resets;
        h0 = hs_errs;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0; active_only = 1'b0;
        for (int cyc = 0; cyc < 20000 && !fin; cyc++) begin
            @(negedge clk);
            start = 1'b0;
            if (id_valid) begin
                if (nf < 8) found[nf] = id_out;
                nf++;
                if (poke && !poked) begin start = 1'b1; poked = 1; end
            end
            if (done || err) fin = 1;
        end
        chk(fin, "R8", "enumeration finished", 64'(fin), 64'd1);
        if (n_exp == 0) begin
            chk(err && !done, mask == 0 ? "R2" : "R5", "error flag", 64'(err), 64'd1);
            chk(nf == 0, mask == 0 ? "R2" : "R5", "no identity", 64'(nf), 64'd0);
            chk(!busy, "R2", "idle after error", 64'(busy), 64'd0);
        end else begin
            chk(done && !err && !busy, "R8", "done state", {61'd0, done, err, busy}, 64'd4);
            chk(nf == n_exp, "R6", "identity count", 64'(nf), 64'(n_exp));
            for (int k = 0; k < n_exp && k < nf; k++)
                chk(found[k] == expv[k], "R4", "identity in order (R6 R7)", found[k], expv[k]);
            chk(n_resets - r0 == n_exp, "R6", "one reset per pass", 64'(n_resets - r0), 64'(n_exp));
        end
        if (mask != 0)
            chk(last_cmd == (act ? 8'hEC : 8'hF0), "R3", "command byte", 64'(last_cmd),
                act ? 64'hEC : 64'hF0);
        chk(hs_errs == h0, "R10", "request held until ack", 64'(hs_errs - h0), 64'd0);
        if (done) begin
            bit quiet = 1;
            repeat (5) begin @(negedge clk); if (bit_req) quiet = 0; end
            chk(quiet, "R8", "no requests after done", 64'(quiet), 64'd1);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk({busy, done, err, id_valid, bit_req} == 5'b0, "R1", "reset outputs",
            {59'd0, busy, done, err, id_valid, bit_req}, 64'd0);

        // Vector table; successive rows also show that each start clears memory (R9)
        foreach (SCEN[i]) run_enum(SCEN[i][6], SCEN[i][5:0], 1'b0);

        // R9 start pulsed mid-enumeration is ignored: full ordered list still appears
        run_enum(1'b0, 6'h3F, 1'b1);
        // R9 restart after done finds the first identity again
        run_enum(1'b0, 6'h03, 1'b0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule